// File: doc/BRIEF.md
# Dual-Channel Digital Potentiometer Command Controller

A clocked model of the serial control logic of a two-channel digital potentiometer. A host sends 24-bit frames on a serial clock, data line and active-low select. Each frame carries a 4-bit command, a 4-bit address and a 16-bit data word. The block keeps two volatile 10-bit wiper settings and a 16-word by 16-bit nonvolatile store. The first two words of the store hold the saved wiper settings and the other fourteen words are free for the user. All serial inputs are oversampled on the system clock through two-stage synchronizers. A frame is acted on only when the select line is released.

The serial output always presents the 24 bits that were previously held in the frame register, so several devices can be chained. A read command replaces the low 16 bits of that register, so the next frame clocks the requested value out behind the command and address byte. A write to the store holds the ready output low for a fixed number of clocks. Wiper settings are reloaded from the store after reset and on a low pulse of the preset input.

Top module: `dpot_cmd_ctrl`

## Requirements
- R1: A frame is acted on only at the rising edge of cs_ni, and only if exactly 24 rising sck_i edges arrived while cs_ni was low. Bits arrive MSB first: bits 23..20 are the command, bits 19..16 the address, and bits 15..0 the data. Address bit 16 selects the wiper (0 = wiper0, 1 = wiper1). Frames of any other length change nothing.
- R2: During each frame, sdo_o presents, MSB first, the 24 bits the frame register held when the frame began. Before any frame this value is zero.
- R3: Command 9 (read store word at the address) and command 10 (read the selected wiper, zero-extended) replace bits 15..0 of the frame register when cs_ni rises. The next frame therefore shifts out {command byte, value}.
- R4: Command 11 loads data bits 9..0 into the selected wiper. Command 3 writes all 16 data bits to store word A3..A0.
- R5: Command 14 adds one to the selected wiper and command 15 adds one to both wipers; both hold at 0x3FF. Command 6 subtracts one from the selected wiper and command 7 from both; both hold at 0.
- R6: Command 12 (selected wiper) and command 13 (both) double the setting; any value of 0x200 or above becomes 0x3FF. Command 4 (selected) and command 5 (both) halve the setting. The data bits are ignored by these commands.
- R7: Command 1 copies store word A0 into the selected wiper. Command 2 saves the selected wiper into store word A0. Command 8 reloads both wipers from store words 0 and 1. Command 0 does nothing to the wipers or the store.
- R8: hipower_o is set by command 1 and cleared only by command 0.
- R9: After reset, both wipers hold the low 10 bits of store words 0 and 1. Store words 0 and 1 reset to 0x200 and all other words reset to 0. A falling edge on pr_ni reloads both wipers from the store.
- R10: While wp_ni is low, commands 2 and 3 leave the store unchanged and do not start a busy period. Wiper commands still execute.
- R11: Each store write drives ready_o low for BUSY_CYCLES clocks. Any frame that completes while ready_o is low is not executed.
- R12: When a pr_ni falling edge and the end of a wiper-changing frame reach the logic in the same clock, the reload from the store decides the wiper value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock; data is sampled on its rising edge |
| sdi_i | input | 1 | Serial data in |
| cs_ni | input | 1 | Active-low frame select |
| wp_ni | input | 1 | Active-low store write protect |
| pr_ni | input | 1 | Active-low preset; its falling edge reloads the wipers |
| sdo_o | output | 1 | Serial data out (frame register MSB) |
| wiper0_o | output | 10 | Wiper 0 setting |
| wiper1_o | output | 10 | Wiper 1 setting |
| ready_o | output | 1 | Low while a store write is in progress |
| hipower_o | output | 1 | High between command 1 and the next command 0 |

## Verification
A preset falling edge and the completion of a wiper command can land in the same clock, because pr_ni and cs_ni pass through synchronizers of equal depth. The bench provokes this by releasing cs_ni at the same instant it pulls pr_ni low at the end of an increment frame. It then expects the wiper to equal the stored value, not the incremented one. Readback and daisy-chain shifting also share one register in one cycle. Every frame's captured sdo_o bits are compared against a bench image of that register, including the image with a read value patched in.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  typedef enum logic [3:0] {
    CMD_NOP     = 4'd0,
    CMD_M2W     = 4'd1,
    CMD_W2M     = 4'd2,
    CMD_WRMEM   = 4'd3,
    CMD_SHR1    = 4'd4,
    CMD_SHR2    = 4'd5,
    CMD_DEC1    = 4'd6,
    CMD_DEC2    = 4'd7,
    CMD_RELOAD  = 4'd8,
    CMD_RDMEM   = 4'd9,
    CMD_RDWIP   = 4'd10,
    CMD_WRWIP   = 4'd11,
    CMD_SHL1    = 4'd12,
    CMD_SHL2    = 4'd13,
    CMD_INC1    = 4'd14,
    CMD_INC2    = 4'd15
  } cmd_e;

  typedef enum logic [2:0] {
    OP_HOLD, OP_LOAD, OP_INC, OP_DEC, OP_SHL, OP_SHR
  } wop_e;
endpackage

// File: rtl/dpot_spi_shift.sv
module dpot_spi_shift #(
  parameter int FRAME_W = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sck_i,
  input  logic               sdi_i,
  input  logic               cs_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] load_word_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               done_o,
  output logic               full_o,
  output logic               sdo_o
);
  localparam int CW = $clog2(FRAME_W + 2);
  localparam logic [CW-1:0] CNT_MAX = CW'(FRAME_W + 1);

  logic [2:0] sck_s, cs_s;
  logic [1:0] sdi_s;
  logic [CW-1:0] cnt_q;
  logic [FRAME_W-1:0] sh_q;
  logic sck_rise, cs_rise, cs_fall, active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_s <= '0;
      cs_s  <= '1;
      sdi_s <= '0;
    end else begin
      sck_s <= {sck_s[1:0], sck_i};
      cs_s  <= {cs_s[1:0], cs_ni};
      sdi_s <= {sdi_s[0], sdi_i};
    end
  end

  assign sck_rise = sck_s[1] & ~sck_s[2];
  assign cs_rise  = cs_s[1] & ~cs_s[2];
  assign cs_fall  = ~cs_s[1] & cs_s[2];
  assign active   = ~cs_s[1];

  // count saturates above the frame length so long frames stay invalid
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (cs_fall) cnt_q <= '0;
    else if (active && sck_rise && cnt_q != CNT_MAX) cnt_q <= cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else if (load_i) sh_q <= load_word_i;
    else if (active && sck_rise) sh_q <= {sh_q[FRAME_W-2:0], sdi_s[1]};
  end

  assign frame_o = sh_q;
  assign done_o  = cs_rise;
  assign full_o  = (cnt_q == CW'(FRAME_W));
  assign sdo_o   = sh_q[FRAME_W-1];

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_s[1] && cs_s[2] && !load_i) |=> $stable(sh_q)); // R2
  AST_LOAD_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (cs_rise && full_o)); // R3
endmodule

// File: rtl/dpot_wiper_alu.sv
module dpot_wiper_alu import dpot_pkg::*; #(
  parameter int W = 10
) (
  input  wop_e         op_i,
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] load_i,
  output logic [W-1:0] nxt_o
);
  localparam logic [W-1:0] MAXV = '1;

  always_comb begin
    nxt_o = cur_i;
    case (op_i)
      OP_LOAD: nxt_o = load_i;
      OP_INC:  if (cur_i != MAXV) nxt_o = cur_i + W'(1);
      OP_DEC:  if (cur_i != '0) nxt_o = cur_i - W'(1);
      OP_SHL:  nxt_o = cur_i[W-1] ? MAXV : {cur_i[W-2:0], 1'b0};
      OP_SHR:  nxt_o = {1'b0, cur_i[W-1:1]};
      default: nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/dpot_nvm.sv
module dpot_nvm #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 16,
  parameter int AW    = 4,
  parameter logic [WIDTH-1:0] SLOT_INIT = 16'h0200
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [WIDTH-1:0] slot0_o,
  output logic [WIDTH-1:0] slot1_o
);
  logic [WIDTH-1:0] words [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    localparam logic [WIDTH-1:0] RST_V = (g < 2) ? SLOT_INIT : '0;
    logic [WIDTH-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) word_q <= RST_V;
      else if (we_i && waddr_i == AW'(g)) word_q <= wdata_i;
    end
    assign words[g] = word_q;
  end

  assign rdata_o = words[raddr_i];
  assign slot0_o = words[0];
  assign slot1_o = words[1];
endmodule

// File: rtl/dpot_cmd_ctrl.sv
module dpot_cmd_ctrl import dpot_pkg::*; #(
  parameter int WIPER_W     = 10,
  parameter int MEM_DEPTH   = 16,
  parameter int MEM_W       = 16,
  parameter int BUSY_CYCLES = 300,
  parameter logic [WIPER_W-1:0] WIPER_INIT = 10'h200
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sck_i,
  input  logic               sdi_i,
  input  logic               cs_ni,
  input  logic               wp_ni,
  input  logic               pr_ni,
  output logic               sdo_o,
  output logic [WIPER_W-1:0] wiper0_o,
  output logic [WIPER_W-1:0] wiper1_o,
  output logic               ready_o,
  output logic               hipower_o
);
  localparam int FRAME_W = MEM_W + 8;
  localparam int AW      = $clog2(MEM_DEPTH);
  localparam int BUSY_W  = $clog2(BUSY_CYCLES + 1);

  logic [FRAME_W-1:0] frame, load_word;
  logic done, full, load_en;

  dpot_spi_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i, .rst_ni, .sck_i, .sdi_i, .cs_ni,
    .load_i(load_en), .load_word_i(load_word),
    .frame_o(frame), .done_o(done), .full_o(full), .sdo_o
  );

  // pr/wp use the same sync depth as cs so edges line up
  logic [2:0] pr_s;
  logic [1:0] wp_s;
  logic restore_pend, pr_fall, restore;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pr_s <= '1;
      wp_s <= '1;
      restore_pend <= 1'b1;
    end else begin
      pr_s <= {pr_s[1:0], pr_ni};
      wp_s <= {wp_s[0], wp_ni};
      restore_pend <= 1'b0;
    end
  end

  assign pr_fall = pr_s[2] & ~pr_s[1];
  assign restore = restore_pend | pr_fall;

  cmd_e cmd;
  logic [3:0] addr_f;
  logic [MEM_W-1:0] data_f;
  logic sel, exec;

  assign cmd    = cmd_e'(frame[FRAME_W-1 -: 4]);
  assign addr_f = frame[FRAME_W-5 -: 4];
  assign data_f = frame[MEM_W-1:0];
  assign sel    = addr_f[0];
  assign exec   = done & full & ready_o;

  logic [1:0][WIPER_W-1:0] wiper_q, wiper_d, ld_val;
  logic [1:0][MEM_W-1:0] slot;
  wop_e op [2];

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      logic hit;
      hit = (sel == i[0]);
      op[i] = OP_HOLD;
      ld_val[i] = slot[i][WIPER_W-1:0];
      if (restore) begin
        op[i] = OP_LOAD;
      end else if (exec) begin
        case (cmd)
          CMD_M2W:    if (hit) op[i] = OP_LOAD;
          CMD_RELOAD: op[i] = OP_LOAD;
          CMD_WRWIP:  if (hit) begin
                        op[i] = OP_LOAD;
                        ld_val[i] = data_f[WIPER_W-1:0];
                      end
          CMD_INC1:   if (hit) op[i] = OP_INC;
          CMD_INC2:   op[i] = OP_INC;
          CMD_DEC1:   if (hit) op[i] = OP_DEC;
          CMD_DEC2:   op[i] = OP_DEC;
          CMD_SHL1:   if (hit) op[i] = OP_SHL;
          CMD_SHL2:   op[i] = OP_SHL;
          CMD_SHR1:   if (hit) op[i] = OP_SHR;
          CMD_SHR2:   op[i] = OP_SHR;
          default:    op[i] = OP_HOLD;
        endcase
      end
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_wiper
    dpot_wiper_alu #(.W(WIPER_W)) u_alu (
      .op_i(op[g]), .cur_i(wiper_q[g]), .load_i(ld_val[g]), .nxt_o(wiper_d[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wiper_q <= '0;
    else wiper_q <= wiper_d;
  end

  logic mem_we, is_wr;
  logic [AW-1:0] waddr;
  logic [MEM_W-1:0] wdata, rdata, rb_val;

  assign is_wr  = (cmd == CMD_W2M) || (cmd == CMD_WRMEM);
  assign mem_we = exec & is_wr & wp_s[1];
  assign waddr  = (cmd == CMD_W2M) ? AW'(sel) : addr_f[AW-1:0];
  assign wdata  = (cmd == CMD_W2M) ? MEM_W'(wiper_q[sel]) : data_f;

  dpot_nvm #(.DEPTH(MEM_DEPTH), .WIDTH(MEM_W), .AW(AW), .SLOT_INIT(MEM_W'(WIPER_INIT))) u_nvm (
    .clk_i, .rst_ni, .we_i(mem_we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_i(addr_f[AW-1:0]), .rdata_o(rdata), .slot0_o(slot[0]), .slot1_o(slot[1])
  );

  assign load_en   = exec & ((cmd == CMD_RDMEM) || (cmd == CMD_RDWIP));
  assign rb_val    = (cmd == CMD_RDMEM) ? rdata : MEM_W'(wiper_q[sel]);
  assign load_word = {frame[FRAME_W-1 -: 8], rb_val};

  logic hp_q;
  logic [BUSY_W-1:0] busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hp_q <= 1'b0;
    else if (exec && cmd == CMD_M2W) hp_q <= 1'b1;
    else if (exec && cmd == CMD_NOP) hp_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= '0;
    else if (mem_we) busy_q <= BUSY_W'(BUSY_CYCLES);
    else if (busy_q != '0) busy_q <= busy_q - BUSY_W'(1);
  end

  assign ready_o   = (busy_q == '0);
  assign hipower_o = hp_q;
  assign wiper0_o  = wiper_q[0];
  assign wiper1_o  = wiper_q[1];

  AST_WIPER_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wiper_q) |-> ($past(done) || $past(restore))); // R1
  AST_INC_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wiper_q[0] == '1 && op[0] == OP_INC) |=> (wiper_q[0] == '1)); // R5
  AST_HP_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hipower_o) |-> $past(done)); // R8
  AST_WP_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wp_s[1] |=> $stable(slot)); // R10
  AST_RDY_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> $past(done)); // R11
  AST_NO_EXEC_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !restore) |=> $stable(wiper_q)); // R11
endmodule

// File: tb/test_dpot_cmd_ctrl.sv
module test_dpot_cmd_ctrl;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int BUSY = 300;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sck_i = 1'b0, sdi_i = 1'b0, cs_ni = 1'b1, wp_ni = 1'b1, pr_ni = 1'b1;
  logic sdo_o, ready_o, hipower_o;
  logic [9:0] wiper0_o, wiper1_o;

  always #2.5 clk = ~clk;

  dpot_cmd_ctrl #(.BUSY_CYCLES(BUSY)) i_dpot_cmd_ctrl (
    .clk_i(clk), .rst_ni, .sck_i, .sdi_i, .cs_ni, .wp_ni, .pr_ni,
    .sdo_o, .wiper0_o, .wiper1_o, .ready_o, .hipower_o
  );

  int n_tests = 0, n_fail = 0;
  logic [15:0] m_mem [16];
  logic [9:0]  m_w [2];
  logic [23:0] m_sh;
  bit m_hp, m_busy, m_wp;
  logic [23:0] got;
  bit wrote;

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] f_inc(input logic [9:0] v);
    return (v == 10'h3FF) ? v : v + 10'd1;
  endfunction
  function automatic logic [9:0] f_dec(input logic [9:0] v);
    return (v == 10'h0) ? v : v - 10'd1;
  endfunction
  function automatic logic [9:0] f_shl(input logic [9:0] v);
    return v[9] ? 10'h3FF : {v[8:0], 1'b0};
  endfunction

  task automatic model_exec(input logic [23:0] word, output bit wr);
    logic [3:0] c, a;
    logic s;
    logic [15:0] d;
    c = word[23:20]; a = word[19:16]; s = a[0]; d = word[15:0];
    wr = 0;
    case (c)
      4'd0:  m_hp = 0;
      4'd1:  begin m_w[s] = m_mem[s][9:0]; m_hp = 1; end
      4'd2:  if (m_wp) begin m_mem[s] = {6'd0, m_w[s]}; wr = 1; end
      4'd3:  if (m_wp) begin m_mem[a] = d; wr = 1; end
      4'd4:  m_w[s] = m_w[s] >> 1;
      4'd5:  begin m_w[0] = m_w[0] >> 1; m_w[1] = m_w[1] >> 1; end
      4'd6:  m_w[s] = f_dec(m_w[s]);
      4'd7:  begin m_w[0] = f_dec(m_w[0]); m_w[1] = f_dec(m_w[1]); end
      4'd8:  begin m_w[0] = m_mem[0][9:0]; m_w[1] = m_mem[1][9:0]; end
      4'd9:  m_sh[15:0] = m_mem[a];
      4'd10: m_sh[15:0] = {6'd0, m_w[s]};
      4'd11: m_w[s] = d[9:0];
      4'd12: m_w[s] = f_shl(m_w[s]);
      4'd13: begin m_w[0] = f_shl(m_w[0]); m_w[1] = f_shl(m_w[1]); end
      4'd14: m_w[s] = f_inc(m_w[s]);
      default: begin m_w[0] = f_inc(m_w[0]); m_w[1] = f_inc(m_w[1]); end
    endcase
  endtask

  // send nbits of word MSB first, capture sdo, update the bench model
  task automatic xfer(input logic [23:0] word, input int nbits, input bit pr_end,
                      output logic [23:0] cap, output bit wr);
    logic [23:0] exp_out;
    logic [15:0] s0, s1;
    exp_out = m_sh;
    cap = '0;
    wr = 0;
    cs_ni = 1'b0;
    wclk(4);
    for (int b = 0; b < nbits; b++) begin
      logic bv;
      bv = (b < 24) ? word[23-b] : 1'b0;
      sdi_i = bv;
      wclk(4);
      cap = {cap[22:0], sdo_o};
      sck_i = 1'b1;
      wclk(4);
      sck_i = 1'b0;
      m_sh = {m_sh[22:0], bv};
    end
    wclk(4);
    cs_ni = 1'b1;
    if (pr_end) pr_ni = 1'b0;
    s0 = m_mem[0]; s1 = m_mem[1];
    if (nbits == 24 && !m_busy) model_exec(word, wr);
    if (pr_end) begin m_w[0] = s0[9:0]; m_w[1] = s1[9:0]; end
    wclk(8);
    pr_ni = 1'b1;
    wclk(6);
    if (nbits == 24) chk("R2 sdo", cap, exp_out);
  endtask

  task automatic chk_state(input string tag);
    chk({tag, " w0"}, wiper0_o, m_w[0]);
    chk({tag, " w1"}, wiper1_o, m_w[1]);
    chk({tag, " hp"}, hipower_o, m_hp);
  endtask

  task automatic wait_busy();
    chk("R11 ready low", ready_o, 1'b0);
    wclk(BUSY);
    m_busy = 0;
    chk("R11 ready back", ready_o, 1'b1);
  endtask

  task automatic pr_pulse();
    pr_ni = 1'b0;
    wclk(6);
    pr_ni = 1'b1;
    wclk(6);
    m_w[0] = m_mem[0][9:0];
    m_w[1] = m_mem[1][9:0];
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) m_mem[i] = (i < 2) ? 16'h0200 : 16'h0;
    m_w[0] = 10'h200; m_w[1] = 10'h200;
    m_sh = '0; m_hp = 0; m_busy = 0; m_wp = 1;
    void'($urandom(32'd4711));
    wclk(5);
    rst_ni = 1'b1;
    wclk(10);
    // R9 reset restore
    chk_state("R9 reset");
    chk("R9 ready", ready_o, 1'b1);
    chk("R2 sdo idle", sdo_o, 1'b0);

    // R4 wiper loads
    xfer(24'hB00100, 24, 0, got, wrote); chk_state("R4 load w0");
    xfer(24'hB103FE, 24, 0, got, wrote); chk_state("R4 load w1");
    // R5 saturating steps
    xfer(24'hF00000, 24, 0, got, wrote); chk_state("R5 inc both");
    xfer(24'hE10000, 24, 0, got, wrote); chk_state("R5 inc sat");
    chk("R5 w1 max", wiper1_o, 10'h3FF);
    xfer(24'hB00001, 24, 0, got, wrote);
    xfer(24'h600000, 24, 0, got, wrote);
    xfer(24'h60FFFF, 24, 0, got, wrote); chk_state("R5 dec sat");
    chk("R5 w0 zero", wiper0_o, 10'h0);
    // R6 shifts ignore data
    xfer(24'hB00200, 24, 0, got, wrote);
    xfer(24'hC0FFFF, 24, 0, got, wrote);
    chk("R6 shl sat", wiper0_o, 10'h3FF);
    xfer(24'h40ABCD, 24, 0, got, wrote);
    chk("R6 shr", wiper0_o, 10'h1FF);

    // R4/R3 store write and readback
    xfer(24'h35AAAA, 24, 0, got, wrote);
    m_busy = wrote; wait_busy();
    xfer(24'h950000, 24, 0, got, wrote);
    xfer(24'h000000, 24, 0, got, wrote);
    chk("R3 read store", got, 24'h95AAAA);
    xfer(24'hA10000, 24, 0, got, wrote);
    xfer(24'h000000, 24, 0, got, wrote);
    chk("R3 read wiper", got, 24'hA103FF);

    // R10 write protect
    wp_ni = 1'b0; m_wp = 0;
    wclk(4);
    xfer(24'h351234, 24, 0, got, wrote);
    chk("R10 no busy", ready_o, 1'b1);
    xfer(24'hB00033, 24, 0, got, wrote); chk_state("R10 wiper runs");
    xfer(24'h950000, 24, 0, got, wrote);
    xfer(24'h000000, 24, 0, got, wrote);
    chk("R10 store kept", got, 24'h95AAAA);
    wp_ni = 1'b1; m_wp = 1;
    wclk(4);

    // R11 frame ignored while busy
    xfer(24'h370001, 24, 0, got, wrote);
    m_busy = wrote;
    xfer(24'hB00055, 24, 0, got, wrote);
    chk("R11 ignored", wiper0_o, 10'h033);
    wait_busy();

    // R1 wrong lengths
    xfer(24'hB00077, 23, 0, got, wrote); chk_state("R1 short");
    xfer(24'hB00077, 25, 0, got, wrote); chk_state("R1 long");
    chk("R1 short w0", wiper0_o, 10'h033);

    // R8 power flag, R7 copy
    xfer(24'h100000, 24, 0, got, wrote); chk_state("R8 set");
    chk("R7 m2w", wiper0_o, 10'h200);
    xfer(24'hE00000, 24, 0, got, wrote); chk_state("R8 holds");
    xfer(24'h000000, 24, 0, got, wrote); chk_state("R8 clear");
    // R7 save and reload
    xfer(24'hB10123, 24, 0, got, wrote);
    xfer(24'h210000, 24, 0, got, wrote);
    m_busy = wrote; wait_busy();
    xfer(24'hB10000, 24, 0, got, wrote);
    xfer(24'h800000, 24, 0, got, wrote); chk_state("R7 reload");
    chk("R7 w1 saved", wiper1_o, 10'h123);

    // R9 preset pulse
    xfer(24'hB00011, 24, 0, got, wrote);
    pr_pulse(); chk_state("R9 preset");
    // R12 preset coincident with increment
    xfer(24'hB00050, 24, 0, got, wrote);
    xfer(24'hE00000, 24, 1, got, wrote); chk_state("R12 collide");
    chk("R12 w0", wiper0_o, 10'h200);

    // random mix
    for (int it = 0; it < 150; it++) begin
      logic [23:0] w;
      w = $urandom();
      if (($urandom() % 6) == 0) begin wp_ni = 1'b0; m_wp = 0; end
      else begin wp_ni = 1'b1; m_wp = 1; end
      wclk(4);
      xfer(w, 24, 0, got, wrote);
      chk_state("R1 rand");
      if (wrote) begin m_busy = 1; wait_busy(); end
      if (($urandom() % 10) == 0) begin pr_pulse(); chk_state("R9 rand"); end
    end
    finish_run();
  end
endmodule